// File: doc/BRIEF.md
# Synchronized External Event Counter

This block counts edges of an asynchronous signal. A select input picks the signal: an external pin or a prescaled tick. The chosen signal passes through a two-stage synchronizer. A registered edge detector follows it, and a polarity bit chooses whether rising or falling edges count.

When the block is enabled, its count register is cleared. The first qualifying edge after enable loads a programmable start value, and each later edge adds one. When the count reaches a programmable compare value, a sticky compare flag is raised. On the next edge the counter either reloads the start value or keeps counting, depending on a reload bit. Rolling past the all-ones value raises a sticky overflow flag.

Each flag has its own interrupt enable and its own clear input, which clears the flag when written with 1. The count is visible on an output port at all times. The source signal must change at less than a quarter of the clock rate.

Top module: `event_counter`

## Requirements
- R1: `src_sel`=0 selects `pin_in` and `src_sel`=1 selects `tick_in`; the unselected input has no effect. A source change driven between clock edges updates `count` at the third rising clock edge after it, and not earlier.
- R2: In the cycle after `en` rises, `count` is 0. The first qualifying edge after that loads `load_val` into `count`.
- R3: Each qualifying edge after the first adds one to `count`, except in the reload case of R6.
- R4: With `inv`=0 only rising (0-to-1) source edges are counted. With `inv`=1 only falling (1-to-0) source edges are counted.
- R5: When an edge makes `count` equal to `cmp_val`, `cmp_flag` is set in the same cycle as the count update, and it stays set until it is cleared.
- R6: On the first edge after `count` equals `cmp_val`, `count` reloads `load_val` if `reload_mode`=1. If `reload_mode`=0 it increments.
- R7: An increment from all ones wraps `count` to 0 and sets `ovf_flag`, which stays set until it is cleared.
- R8: `cmp_irq` is high exactly when both `cmp_flag` and `cmp_ie` are high. `ovf_irq` is high exactly when both `ovf_flag` and `ovf_ie` are high.
- R9: A 1 on `cmp_clr` or `ovf_clr` clears the matching flag at the next clock edge. A new set in the same cycle takes precedence over the clear.
- R10: While `en`=0, source edges are ignored, and `count` and both flags keep their values.
- R11: After reset, `count` is 0 and both flags and both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counter enable; a rising edge clears the count |
| src_sel | input | 1 | Event source: 0 pin, 1 tick |
| pin_in | input | 1 | Asynchronous external event pin |
| tick_in | input | 1 | Prescaled tick event source |
| inv | input | 1 | Edge polarity: 0 rising, 1 falling |
| reload_mode | input | 1 | Reload start value on the edge after a match |
| load_val | input | CW | Start value loaded by the first edge and by reloads |
| cmp_val | input | CW | Compare value |
| cmp_ie | input | 1 | Compare interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cmp_clr | input | 1 | Write-1 clear of the compare flag |
| ovf_clr | input | 1 | Write-1 clear of the overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |
| count | output | CW | Current counter value |

## Verification
The embedded properties watch four things on every cycle:
- the count holds steady while the block is disabled;
- the count is zero right after enable;
- a rising compare flag coincides with the count equal to the compare value;
- a rising overflow flag coincides with a wrap from all ones to zero.

Other behaviours are only visible across a sequence of stimulus, so the bench scenarios cover them:
- the three-edge synchronizer latency;
- the first-edge load versus later increments;
- polarity selection;
- source selection;
- reload on the edge after a match;
- the write-1 clears.

// File: rtl/event_counter.sv
module event_counter #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          src_sel,
  input  logic          pin_in,
  input  logic          tick_in,
  input  logic          inv,
  input  logic          reload_mode,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] cmp_val,
  input  logic          cmp_ie,
  input  logic          ovf_ie,
  input  logic          cmp_clr,
  input  logic          ovf_clr,
  output logic          cmp_flag,
  output logic          ovf_flag,
  output logic          cmp_irq,
  output logic          ovf_irq,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};

  logic          sync1, sync2, sync3;
  logic          en_q, armed;
  logic          hit, at_match, do_reload, wrap;
  logic [CW-1:0] nxt;

  wire src_raw = src_sel ? tick_in : pin_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= src_raw;
      sync2 <= sync1;
      sync3 <= sync2;
    end

  assign hit       = en & en_q & (inv ? (~sync2 & sync3) : (sync2 & ~sync3));
  assign at_match  = (count == cmp_val);
  assign do_reload = reload_mode & at_match;
  assign wrap      = ~armed & ~do_reload & (count == ALL_ONES);

  always_comb begin
    if (armed || do_reload) nxt = load_val;
    else                    nxt = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= 1'b0;
      armed <= 1'b0;
      count <= '0;
    end else begin
      en_q <= en;
      if (en && !en_q) begin
        count <= '0;
        armed <= 1'b1;
      end else if (hit) begin
        count <= nxt;
        armed <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      cmp_flag <= (cmp_flag & ~cmp_clr) | (hit & (nxt == cmp_val));
      ovf_flag <= (ovf_flag & ~ovf_clr) | (hit & wrap);
    end

  assign cmp_irq = cmp_flag & cmp_ie;
  assign ovf_irq = ovf_flag & ovf_ie;

  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

  // R2
  enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> (count == '0));

  // R5
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> (count == $past(cmp_val)));

  // R7
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (count == '0 && $past(count) == ALL_ONES));

endmodule

// File: tb/test_event_counter.sv
`timescale 1ns/1ps
module test_event_counter;
  localparam int CW = 24;

  logic clk = 0, rst_n = 0;
  logic en = 0, src_sel = 0, pin_in = 0, tick_in = 0, inv = 0, reload_mode = 0;
  logic [CW-1:0] load_val = '0, cmp_val = '0;
  logic cmp_ie = 0, ovf_ie = 0, cmp_clr = 0, ovf_clr = 0;
  logic cmp_flag, ovf_flag, cmp_irq, ovf_irq;
  logic [CW-1:0] count;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  event_counter #(.CW(CW)) i_event_counter (
    .clk(clk), .rst_n(rst_n), .en(en), .src_sel(src_sel), .pin_in(pin_in),
    .tick_in(tick_in), .inv(inv), .reload_mode(reload_mode), .load_val(load_val),
    .cmp_val(cmp_val), .cmp_ie(cmp_ie), .ovf_ie(ovf_ie), .cmp_clr(cmp_clr),
    .ovf_clr(ovf_clr), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
    .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .count(count));

  typedef struct packed {
    logic          inv;
    logic          rld;
    logic [CW-1:0] ld;
    logic [CW-1:0] cp;
    logic [7:0]    n;
    logic [CW-1:0] exp_cnt;
    logic          exp_cf;
    logic          exp_of;
  } vec_t;

  localparam vec_t TBL [4] = '{
    '{1'b0, 1'b0, 24'd5,       24'd8,  8'd4, 24'd8,  1'b1, 1'b0},
    '{1'b1, 1'b1, 24'd10,      24'd12, 8'd5, 24'd11, 1'b1, 1'b0},
    '{1'b0, 1'b0, 24'hFFFFFE,  24'd3,  8'd4, 24'd1,  1'b0, 1'b1},
    '{1'b0, 1'b1, 24'd0,       24'd2,  8'd3, 24'd2,  1'b1, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(bit use_tick, bit idle);
    @(negedge clk);
    if (use_tick) tick_in = ~idle; else pin_in = ~idle;
    repeat (4) @(negedge clk);
    if (use_tick) tick_in = idle; else pin_in = idle;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); cmp_clr = 1; ovf_clr = 1;
    @(negedge clk); cmp_clr = 0; ovf_clr = 0;
  endtask

  task automatic restart(logic i, logic r, logic [CW-1:0] ld, logic [CW-1:0] cp);
    @(negedge clk);
    en = 0; inv = i; reload_mode = r; load_val = ld; cmp_val = cp;
    pin_in = i; tick_in = i;
    repeat (6) @(negedge clk);
    clear_flags();
    en = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 count", 32'(count), 0);
    check("R11 flags", {cmp_flag, ovf_flag, cmp_irq, ovf_irq}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    foreach (TBL[k]) begin
      restart(TBL[k].inv, TBL[k].rld, TBL[k].ld, TBL[k].cp);
      check("R2 cleared on enable", 32'(count), 0);
      pulse(0, TBL[k].inv);
      check("R2 first edge loads", 32'(count), 32'(TBL[k].ld));
      for (int j = 1; j < int'(TBL[k].n); j++) pulse(0, TBL[k].inv);
      // R3 R4 R6 R7 per vector
      check("R3/R6 final count", 32'(count), 32'(TBL[k].exp_cnt));
      check("R5 compare flag", 32'(cmp_flag), 32'(TBL[k].exp_cf));
      check("R7 overflow flag", 32'(ovf_flag), 32'(TBL[k].exp_of));
    end

    // R10 disabled: edges ignored, state held
    @(negedge clk); en = 0;
    pulse(0, 0);
    check("R10 count held", 32'(count), 2);
    check("R10 flag held", 32'(cmp_flag), 1);

    // R8 interrupt gating
    cmp_ie = 1; ovf_ie = 1; @(negedge clk);
    check("R8 cmp_irq", 32'(cmp_irq), 1);
    check("R8 ovf_irq low", 32'(ovf_irq), 0);

    // R9 write-1 clear
    @(negedge clk); cmp_clr = 1;
    @(negedge clk); cmp_clr = 0;
    check("R9 cmp cleared", 32'(cmp_flag), 0);
    check("R9 irq follows", 32'(cmp_irq), 0);

    // R4 wrong polarity: falling edge ignored with inv=0
    restart(0, 0, 24'd40, 24'd99);
    @(negedge clk); pin_in = 1; repeat (6) @(negedge clk);
    check("R4 rising counted", 32'(count), 40);
    pin_in = 0; repeat (6) @(negedge clk);
    check("R4 falling ignored", 32'(count), 40);

    // R1 source select and latency
    restart(0, 0, 24'd100, 24'd200);
    src_sel = 1;
    pulse(0, 0);
    check("R1 unselected pin ignored", 32'(count), 0);
    pulse(1, 0);
    check("R1 tick selected", 32'(count), 100);
    @(negedge clk); tick_in = 1;
    repeat (2) @(negedge clk);
    check("R1 no update before third edge", 32'(count), 100);
    @(negedge clk);
    check("R1 update at third edge", 32'(count), 101);
    tick_in = 0; repeat (4) @(negedge clk);
    src_sel = 0;

    // R7 R8 wrap with overflow interrupt enabled
    restart(0, 0, 24'hFFFFFF, 24'd500);
    pulse(0, 0);
    check("R7 loaded max", 32'(count), 32'hFFFFFF);
    check("R7 no overflow yet", 32'(ovf_flag), 0);
    pulse(0, 0);
    check("R7 wrapped", 32'(count), 0);
    check("R8 ovf_irq", 32'(ovf_irq), 1);

    // R6 reload_mode=0 continues past match
    restart(0, 0, 24'd7, 24'd7);
    pulse(0, 0);
    check("R5 match on load", 32'(cmp_flag), 1);
    pulse(0, 0);
    check("R6 no reload increments", 32'(count), 8);

    finish_run();
  end
endmodule